// File: doc/BRIEF.md
# CEC Bit Timing Receiver

This block watches the single-wire CEC line and turns its low pulses into decoded bit events. It is clocked by the system clock. A one-cycle timebase strobe, nominally 32768 Hz, advances its duration counter. The line first passes through a two-flop synchroniser and an edge detector. One counter measures the time since the last falling edge, and its value is captured at each rising edge as the low time. The high time is the difference between the two.

A small state machine compares the low time and the full period of each pulse against programmable minimum and maximum windows. It first waits for a start bit. After the period of that start bit is confirmed it emits a start-of-frame strobe and decodes data bits. A data bit whose low phase ends before the sampling point is a 1, and any other data bit is a 0. The low time must also fall inside the window for that value. Any violation produces an error pulse and returns the receiver to waiting for a start bit. An overlong low in the data phase is reported as an error-notification low.

After the last bit of a frame, a high phase longer than the data high limit ends the frame quietly. Byte assembly, acknowledge driving and arbitration belong to other blocks.

Top module: `cec_bit_rx`

## Requirements
- R1: After synchronous reset, none of `sof`, `bit_vld`, `err`, `err_notify` pulse while the line stays high, and the receiver waits for a start bit.
- R2: Durations are counted in timebase ticks (cycles with `tick_en` high) only. A low time is the number of ticks from the cycle of the synchronised falling edge up to the cycle before the rising edge. The counter saturates at its maximum value.
- R3: A start bit is accepted when its low time lies in [index 0, index 1] (defaults 115 and 128 ticks) and its total period lies in [index 2, index 3] (defaults 141 and 154). `sof` pulses once, for one cycle, after the falling edge that ends the start bit.
- R4: While waiting for a start bit, a low time outside the start low window gives one `err` pulse and no `sof`.
- R5: In a start bit, a period below index 2 at the next falling edge, or a high phase that lets the period exceed index 3, gives `err` and a return to waiting for a start bit.
- R6: A data bit whose low time is below the sampling point (index 11, default 34) is a 1 and must lie in [index 4, index 5] (13..26). Any other data bit is a 0 and must lie in [index 6, index 7] (43..56). A valid bit pulses `bit_vld` with `bit_val` at its rising edge. Otherwise the block gives `err`.
- R7: A data bit whose total period at the next falling edge is below index 8 (default 67) gives `err`, and the receiver returns to waiting for a start bit.
- R8: After a data bit, a high phase greater than index 9 (default 92) ends the frame without `err`. A high phase of exactly index 9 followed by a falling edge continues the frame.
- R9: A data-phase low time greater than index 10 (default 111) gives `err` and `err_notify` in the same cycle.
- R10: A cycle with `cfg_we` high loads `cfg_val` into threshold `cfg_idx` (0..11 as listed above), and the new value applies to later pulses. Indices 12..15 are ignored. Reset restores every default, defined as the tick count nearest to the nominal time.
- R11: At most one of `sof`, `bit_vld`, `err` is high in any cycle, and `err_notify` is never high without `err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Timebase strobe, one cycle per tick |
| line_in | input | 1 | Asynchronous CEC line level |
| cfg_we | input | 1 | Threshold write enable |
| cfg_idx | input | 4 | Threshold index |
| cfg_val | input | 10 | Threshold value in ticks |
| sof | output | 1 | Start-of-frame strobe |
| bit_vld | output | 1 | Decoded data bit strobe |
| bit_val | output | 1 | Value of the decoded bit |
| err | output | 1 | Timing violation strobe |
| err_notify | output | 1 | Overlong data low seen (with err) |

## Verification
Some properties are checked on every cycle. These are the mutual exclusion of the event strobes and the pairing of the notification with an error. They also cover the state reached after each kind of event, the saturation and holding of the counter between ticks, and the loading or ignoring of threshold writes. The scenarios check the behaviour at the window boundaries. For each threshold this means one tick inside and one tick outside. They also cover the quiet end of a frame compared with a high phase that is one tick too long, the recovery into a new start bit after a period error, tick gating at half rate, and reprogrammed thresholds that return to their defaults on reset.

// File: rtl/cec_rx_pkg.sv
package cec_rx_pkg;

    localparam int TICK_HZ = 32768;
    localparam int CNT_W   = 10;
    localparam int THR_N   = 12;
    localparam int IDX_W   = $clog2(THR_N);

    // threshold slots
    localparam int IX_SLO_MIN  = 0;
    localparam int IX_SLO_MAX  = 1;
    localparam int IX_SPER_MIN = 2;
    localparam int IX_SPER_MAX = 3;
    localparam int IX_ONE_MIN  = 4;
    localparam int IX_ONE_MAX  = 5;
    localparam int IX_ZERO_MIN = 6;
    localparam int IX_ZERO_MAX = 7;
    localparam int IX_DPER_MIN = 8;
    localparam int IX_DHI_MAX  = 9;
    localparam int IX_LONG_LO  = 10;
    localparam int IX_SAMPLE   = 11;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_START_HI = 2'd1,
        ST_DATA_LO  = 2'd2,
        ST_DATA_HI  = 2'd3
    } rx_state_e;

    typedef struct packed {
        logic sof;
        logic bit_vld;
        logic bit_val;
        logic err;
        logic err_notify;
    } rx_evt_t;

    // nearest tick count for a duration in microseconds
    function automatic int ticks_of_us(input int us);
        return int'((longint'(us) * longint'(TICK_HZ) + 64'sd500000) / 64'sd1000000);
    endfunction

    function automatic int thr_default(input int idx);
        case (idx)
            IX_SLO_MIN:  return ticks_of_us(3500);
            IX_SLO_MAX:  return ticks_of_us(3900);
            IX_SPER_MIN: return ticks_of_us(4300);
            IX_SPER_MAX: return ticks_of_us(4700);
            IX_ONE_MIN:  return ticks_of_us(400);
            IX_ONE_MAX:  return ticks_of_us(800);
            IX_ZERO_MIN: return ticks_of_us(1300);
            IX_ZERO_MAX: return ticks_of_us(1700);
            IX_DPER_MIN: return ticks_of_us(2050);
            IX_DHI_MAX:  return ticks_of_us(2800);
            IX_LONG_LO:  return ticks_of_us(3400);
            IX_SAMPLE:   return ticks_of_us(1050);
            default:     return 0;
        endcase
    endfunction

endpackage

// File: rtl/cec_line_sync.sv
module cec_line_sync (
    input  logic clk,
    input  logic rst,
    input  logic line_in,
    output logic fall,
    output logic rise
);
    logic meta_q, sync_q, prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= 1'b1;
            sync_q <= 1'b1;
            prev_q <= 1'b1;
        end else begin
            meta_q <= line_in;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign fall = prev_q & ~sync_q;
    assign rise = ~prev_q & sync_q;

endmodule

// File: rtl/cec_dur_counter.sv
module cec_dur_counter #(
    parameter int CW = cec_rx_pkg::CNT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          fall,
    input  logic          rise,
    output logic [CW-1:0] cnt,
    output logic [CW-1:0] low_len
);
    localparam logic [CW-1:0] CMAX = '1;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            low_len <= '0;
        end else begin
            if (fall)
                cnt <= {{(CW-1){1'b0}}, tick};
            else if (tick && cnt != CMAX)
                cnt <= cnt + 1'b1;
            if (rise)
                low_len <= cnt;
        end
    end

    // R2: counter never wraps
    assert_cnt_saturates_R2: assert property (@(posedge clk) disable iff (rst)
        (tick && !fall && cnt == CMAX) |=> (cnt == CMAX));

    // R2: no tick, no edge -> count unchanged
    assert_cnt_holds_R2: assert property (@(posedge clk) disable iff (rst)
        (!tick && !fall) |=> $stable(cnt));

endmodule

// File: rtl/cec_thr_regs.sv
module cec_thr_regs
    import cec_rx_pkg::*;
#(
    parameter int CW   = CNT_W,
    parameter int NTHR = THR_N,
    parameter int IW   = IDX_W
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     we,
    input  logic [IW-1:0]            idx,
    input  logic [CW-1:0]            val,
    output logic [NTHR-1:0][CW-1:0]  thr
);
    for (genvar g = 0; g < NTHR; g++) begin : g_slot
        localparam logic [CW-1:0] RST_VAL = CW'(thr_default(g));
        logic [CW-1:0] q;

        always_ff @(posedge clk) begin
            if (rst)
                q <= RST_VAL;
            else if (we && idx == IW'(g))
                q <= val;
        end

        assign thr[g] = q;

        // R10: a write to this slot lands
        assert_slot_write_R10: assert property (@(posedge clk) disable iff (rst)
            (we && idx == IW'(g)) |=> (q == $past(val)));
    end

    // R10: writes beyond the last slot change nothing
    assert_bad_index_ignored_R10: assert property (@(posedge clk) disable iff (rst)
        (we && idx >= IW'(NTHR)) |=> $stable(thr));

endmodule

// File: rtl/cec_bit_classifier.sv
module cec_bit_classifier
    import cec_rx_pkg::*;
#(
    parameter int CW   = CNT_W,
    parameter int NTHR = THR_N
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    fall,
    input  logic                    rise,
    input  logic [CW-1:0]           cnt,
    input  logic [CW-1:0]           low_len,
    input  logic [NTHR-1:0][CW-1:0] thr,
    output rx_evt_t                 evt
);
    rx_state_e st_q, st_d;
    rx_evt_t   ev_d;
    logic [CW-1:0] high_len;

    assign high_len = cnt - low_len;

    function automatic logic in_win(input logic [CW-1:0] v, input logic [CW-1:0] lo,
                                    input logic [CW-1:0] hi);
        return (v >= lo) && (v <= hi);
    endfunction

    always_comb begin
        st_d = st_q;
        ev_d = '0;
        case (st_q)
            ST_IDLE: begin
                if (rise) begin
                    if (in_win(cnt, thr[IX_SLO_MIN], thr[IX_SLO_MAX]))
                        st_d = ST_START_HI;
                    else
                        ev_d.err = 1'b1;
                end
            end
            ST_START_HI: begin
                if (cnt > thr[IX_SPER_MAX]) begin
                    ev_d.err = 1'b1;
                    st_d     = ST_IDLE;
                end else if (fall) begin
                    if (cnt >= thr[IX_SPER_MIN]) begin
                        ev_d.sof = 1'b1;
                        st_d     = ST_DATA_LO;
                    end else begin
                        ev_d.err = 1'b1;
                        st_d     = ST_IDLE;
                    end
                end
            end
            ST_DATA_LO: begin
                if (rise) begin
                    st_d = ST_IDLE;
                    if (cnt > thr[IX_LONG_LO]) begin
                        ev_d.err        = 1'b1;
                        ev_d.err_notify = 1'b1;
                    end else if (cnt < thr[IX_SAMPLE]) begin
                        if (in_win(cnt, thr[IX_ONE_MIN], thr[IX_ONE_MAX])) begin
                            ev_d.bit_vld = 1'b1;
                            ev_d.bit_val = 1'b1;
                            st_d         = ST_DATA_HI;
                        end else begin
                            ev_d.err = 1'b1;
                        end
                    end else begin
                        if (in_win(cnt, thr[IX_ZERO_MIN], thr[IX_ZERO_MAX])) begin
                            ev_d.bit_vld = 1'b1;
                            st_d         = ST_DATA_HI;
                        end else begin
                            ev_d.err = 1'b1;
                        end
                    end
                end
            end
            ST_DATA_HI: begin
                if (high_len > thr[IX_DHI_MAX]) begin
                    st_d = ST_IDLE;
                end else if (fall) begin
                    if (cnt >= thr[IX_DPER_MIN]) begin
                        st_d = ST_DATA_LO;
                    end else begin
                        ev_d.err = 1'b1;
                        st_d     = ST_IDLE;
                    end
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= ST_IDLE;
            evt  <= '0;
        end else begin
            st_q <= st_d;
            evt  <= ev_d;
        end
    end

    // R11: one event kind per cycle
    assert_one_event_R11: assert property (@(posedge clk) disable iff (rst)
        $onehot0({evt.sof, evt.bit_vld, evt.err}));

    // R9: notification rides on an error
    assert_notify_with_err_R9: assert property (@(posedge clk) disable iff (rst)
        evt.err_notify |-> evt.err);

    // R5: every error leaves the receiver waiting for a start bit
    assert_err_to_idle_R5: assert property (@(posedge clk) disable iff (rst)
        evt.err |-> (st_q == ST_IDLE));

    // R6: a decoded bit leaves the receiver in its high phase
    assert_bit_to_high_R6: assert property (@(posedge clk) disable iff (rst)
        evt.bit_vld |-> (st_q == ST_DATA_HI));

    // R3: start-of-frame only after a start bit high phase
    assert_sof_after_start_R3: assert property (@(posedge clk) disable iff (rst)
        evt.sof |-> ($past(st_q) == ST_START_HI && st_q == ST_DATA_LO));

endmodule

// File: rtl/cec_bit_rx.sv
module cec_bit_rx
    import cec_rx_pkg::*;
#(
    parameter int CW   = CNT_W,
    parameter int NTHR = THR_N,
    parameter int IW   = IDX_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick_en,
    input  logic          line_in,
    input  logic          cfg_we,
    input  logic [IW-1:0] cfg_idx,
    input  logic [CW-1:0] cfg_val,
    output logic          sof,
    output logic          bit_vld,
    output logic          bit_val,
    output logic          err,
    output logic          err_notify
);
    logic fall, rise;
    logic [CW-1:0] cnt, low_len;
    logic [NTHR-1:0][CW-1:0] thr;
    rx_evt_t evt;

    cec_line_sync u_sync (
        .clk     (clk),
        .rst     (rst),
        .line_in (line_in),
        .fall    (fall),
        .rise    (rise)
    );

    cec_dur_counter #(.CW(CW)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick_en),
        .fall    (fall),
        .rise    (rise),
        .cnt     (cnt),
        .low_len (low_len)
    );

    cec_thr_regs #(.CW(CW), .NTHR(NTHR), .IW(IW)) u_thr (
        .clk (clk),
        .rst (rst),
        .we  (cfg_we),
        .idx (cfg_idx),
        .val (cfg_val),
        .thr (thr)
    );

    cec_bit_classifier #(.CW(CW), .NTHR(NTHR)) u_cls (
        .clk     (clk),
        .rst     (rst),
        .fall    (fall),
        .rise    (rise),
        .cnt     (cnt),
        .low_len (low_len),
        .thr     (thr),
        .evt     (evt)
    );

    assign sof        = evt.sof;
    assign bit_vld    = evt.bit_vld;
    assign bit_val    = evt.bit_val;
    assign err        = evt.err;
    assign err_notify = evt.err_notify;

endmodule

// File: tb/test_cec_bit_rx.sv
module test_cec_bit_rx;

    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst, tick_en, line_in, cfg_we;
    logic [3:0] cfg_idx;
    logic [9:0] cfg_val;
    logic sof, bit_vld, bit_val, err, err_notify;

    int n_sof, n_bit, n_err, n_ntf;
    int n_multi, n_lone;
    int bit_log;
    int tick_div, tick_ph;
    int n_checks, n_fail;

    cec_bit_rx i_cec_bit_rx (
        .clk(clk), .rst(rst), .tick_en(tick_en), .line_in(line_in),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_val(cfg_val),
        .sof(sof), .bit_vld(bit_vld), .bit_val(bit_val),
        .err(err), .err_notify(err_notify)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // event monitor
    always @(posedge clk) begin
        if (!rst) begin
            if (sof) n_sof++;
            if (bit_vld) begin
                n_bit++;
                bit_log = (bit_log << 1) | int'(bit_val);
            end
            if (err) n_err++;
            if (err_notify) n_ntf++;
            if ((int'(sof) + int'(bit_vld) + int'(err)) > 1) n_multi++;
            if (err_notify && !err) n_lone++;
        end
    end

    // timebase
    initial begin
        tick_ph = 0;
        tick_en = 1'b1;
        forever begin
            @(negedge clk);
            if (tick_div == 1) tick_en = 1'b1;
            else begin
                tick_ph = 1 - tick_ph;
                tick_en = tick_ph[0];
            end
        end
    end

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic clear_counts();
        n_sof = 0; n_bit = 0; n_err = 0; n_ntf = 0; bit_log = 0;
    endtask

    task automatic do_reset();
        rst = 1'b1; line_in = 1'b1; cfg_we = 1'b0; cfg_idx = '0; cfg_val = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic hold(input logic lvl, input int n);
        line_in = lvl;
        repeat (n * tick_div) @(negedge clk);
    endtask

    task automatic pulse(input int lo, input int hi);
        hold(1'b0, lo);
        hold(1'b1, hi);
    endtask

    task automatic end_frame();
        hold(1'b1, 200);
    endtask

    task automatic cfg_write(input int idx, input int val);
        cfg_idx = 4'(idx); cfg_val = 10'(val); cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
        @(negedge clk);
    endtask

    task automatic expect_counts(input string req, input int es, input int eb,
                                 input int ee, input int en, input int epat);
        chk(req, "sof count", n_sof, es);
        chk(req, "bit count", n_bit, eb);
        chk(req, "err count", n_err, ee);
        chk(req, "notify count", n_ntf, en);
        chk(req, "bit pattern", bit_log, epat);
    endtask

    // R1
    task automatic t_reset();
        do_reset();
        clear_counts();
        hold(1'b1, 60);
        expect_counts("R1", 0, 0, 0, 0, 0);
    endtask

    // R3, R6, R8: clean frame ending with a long high
    task automatic t_frame();
        clear_counts();
        pulse(120, 30);
        pulse(20, 60); pulse(50, 30); pulse(20, 60); pulse(20, 60);
        end_frame();
        expect_counts("R3", 1, 4, 0, 0, 'b1011);
    endtask

    // R3, R4: start low window edges
    task automatic t_start_window();
        clear_counts(); pulse(115, 30); pulse(20, 60); end_frame();
        expect_counts("R3", 1, 1, 0, 0, 1);
        clear_counts(); pulse(128, 26); pulse(50, 30); end_frame();
        expect_counts("R3", 1, 1, 0, 0, 0);
        clear_counts(); pulse(114, 30); end_frame();
        expect_counts("R4", 0, 0, 1, 0, 0);
        clear_counts(); pulse(129, 20); end_frame();
        expect_counts("R4", 0, 0, 1, 0, 0);
    endtask

    // R5: start period too short then recovery, and too long
    task automatic t_start_period();
        clear_counts();
        pulse(120, 20);
        pulse(120, 30); pulse(20, 60); end_frame();
        expect_counts("R5", 1, 1, 1, 0, 1);
        clear_counts();
        hold(1'b0, 120); hold(1'b1, 200); end_frame();
        expect_counts("R5", 0, 0, 1, 0, 0);
    endtask

    task automatic one_bit(input string req, input int lo, input int eb,
                           input int ee, input int en, input int epat);
        clear_counts();
        pulse(120, 30); pulse(lo, 60); end_frame();
        expect_counts(req, 1, eb, ee, en, epat);
    endtask

    // R6: data low windows and sampling point
    task automatic t_data_windows();
        one_bit("R6", 13, 1, 0, 0, 1);
        one_bit("R6", 26, 1, 0, 0, 1);
        one_bit("R6", 12, 0, 1, 0, 0);
        one_bit("R6", 27, 0, 1, 0, 0);
        one_bit("R6", 33, 0, 1, 0, 0);
        one_bit("R6", 43, 1, 0, 0, 0);
        one_bit("R6", 56, 1, 0, 0, 0);
        one_bit("R6", 57, 0, 1, 0, 0);
    endtask

    // R7: data period boundary
    task automatic t_data_period();
        clear_counts();
        pulse(120, 30); pulse(20, 47); pulse(50, 30); end_frame();
        expect_counts("R7", 1, 2, 0, 0, 'b10);
        clear_counts();
        pulse(120, 30); pulse(20, 46);
        pulse(120, 30); pulse(20, 60); end_frame();
        expect_counts("R7", 2, 2, 1, 0, 'b11);
    endtask

    // R8: high phase limit
    task automatic t_high_limit();
        clear_counts();
        pulse(120, 30); pulse(20, 92); pulse(50, 30); end_frame();
        expect_counts("R8", 1, 2, 0, 0, 'b10);
        clear_counts();
        pulse(120, 30); pulse(20, 93); pulse(20, 60); end_frame();
        expect_counts("R8", 1, 1, 1, 0, 1);
    endtask

    // R9: error-notification low
    task automatic t_notify();
        one_bit("R9", 115, 0, 1, 1, 0);
        one_bit("R9", 111, 0, 1, 0, 0);
    endtask

    // R10: programmable thresholds and reset defaults
    task automatic t_config();
        do_reset();
        cfg_write(0, 100);
        clear_counts(); pulse(105, 40); pulse(20, 60); end_frame();
        expect_counts("R10", 1, 1, 0, 0, 1);
        cfg_write(12, 0);
        cfg_write(15, 1);
        clear_counts(); pulse(105, 40); pulse(50, 30); end_frame();
        expect_counts("R10", 1, 1, 0, 0, 0);
        cfg_write(5, 30);
        clear_counts(); pulse(120, 30); pulse(28, 60); end_frame();
        expect_counts("R10", 1, 1, 0, 0, 1);
        do_reset();
        clear_counts(); pulse(105, 40); end_frame();
        expect_counts("R10", 0, 0, 1, 0, 0);
        clear_counts(); pulse(120, 30); pulse(28, 60); end_frame();
        expect_counts("R10", 1, 0, 1, 0, 0);
    endtask

    // R2: ticks every other cycle, durations doubled in cycles
    task automatic t_tick_rate();
        tick_div = 2;
        hold(1'b1, 10);
        clear_counts();
        pulse(120, 30); pulse(20, 60); pulse(50, 30); pulse(13, 60);
        end_frame();
        expect_counts("R2", 1, 3, 0, 0, 'b101);
        clear_counts(); pulse(114, 30); end_frame();
        expect_counts("R2", 0, 0, 1, 0, 0);
        tick_div = 1;
        hold(1'b1, 10);
    endtask

    // R11
    task automatic t_exclusive();
        chk("R11", "cycles with two events", n_multi, 0);
        chk("R11", "notify without err", n_lone, 0);
    endtask

    initial begin
        n_checks = 0; n_fail = 0; n_multi = 0; n_lone = 0;
        tick_div = 1;
        clear_counts();
        t_reset();
        t_frame();
        t_start_window();
        t_start_period();
        t_data_windows();
        t_data_period();
        t_high_limit();
        t_notify();
        t_config();
        t_tick_rate();
        t_exclusive();
        report();
    end

endmodule